// File: doc/BRIEF.md
# Key-Unlocked Indexed Configuration Port

This block is the configuration front end of a multi-function I/O controller. It sits on a byte-wide host I/O bus with a simple synchronous read and write strobe. Two addresses are decoded: an index port and a data port one address above it. A strap input moves both ports between two base locations. While the block is locked, the only write that has any effect is a key byte written to the index port. That byte unlocks the configuration state. In the configuration state, a byte written to the index port chooses a register, and the data port then reads or writes that register.

Indices below 0x30 reach a global register space. That space holds a logical device number, power-enable bits for the floppy, parallel and two serial functions, an oscillator enable, and two plain byte registers. Indices 0x30 and above reach a separate register bank for each logical device, and the logical device number decides which bank they address. Each bank drives an activate bit, a 16-bit I/O base, an IRQ number and a mode byte as outputs. The downstream function logic uses these outputs.

The control is a two-state machine. In `ST_RUN` the block is locked. The transition "unlock" goes from `ST_RUN` to `ST_CFG` on a 0x55 write to the index port. In `ST_CFG` the registers are open. The transition "lock" goes from `ST_CFG` to `ST_RUN` on a 0xAA write to the index port. Reset forces `ST_RUN`.

Top module: `pnp_cfg_port`

## Requirements
- R1: In ST_RUN, a write of 0x55 to the index port moves the block to ST_CFG on the next clock. A write of any other value to the index port leaves it in ST_RUN. `cfg_mode` is 1 exactly in ST_CFG.
- R2: In ST_CFG, a write of 0xAA to the index port returns the block to ST_RUN and leaves the index unchanged. Any other index-port write stores that byte as the current index, and an index-port read returns it.
- R3: With `base_sel`=0 the index port is at 0x3F0 and the data port at 0x3F1. With `base_sel`=1 they are at 0x370 and 0x371. Accesses to any other address have no effect and read 0xFF.
- R4: Index 0x07 holds the logical device number as a full read/write byte.
- R5: Per-device indices act on the bank named by the logical device number. Index 0x30 bit 0 is the activate bit. Indices 0x60 and 0x61 are the high and low bytes of the I/O base. Index 0x70 bits 3:0 are the IRQ number. Index 0xF0 is the mode byte. Writes to one bank leave every other bank unchanged.
- R6: Index 0x22 is the power register. Bit 0 drives `pwr_en[0]` (floppy), bit 3 drives `pwr_en[1]` (parallel), bit 4 drives `pwr_en[2]` (serial 1) and bit 5 drives `pwr_en[3]` (serial 2). Bit 2 of index 0x24 drives `osc_en`. Indices 0x02 and 0x23 are full read/write bytes.
- R7: In ST_RUN, index-port and data-port writes change no register or output, and every read returns 0xFF.
- R8: Reserved bits read back as zero. These are the power register bits other than 5, 4, 3 and 0, the oscillator register bits other than 2, the activate register bits 7:1 and the IRQ register bits 7:4. A read of an unimplemented index returns 0x00.
- R9: Reset puts the block in ST_RUN, sets the logical device number and the index to 0, and clears every activate bit and every other register.
- R10: When the logical device number is 6 or above (no such bank), data-port writes to indices 0x30 and above have no effect and reads of them return 0x00. Global indices still work.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| base_sel | input | 1 | Strap: 0 selects base 0x3F0, 1 selects base 0x370 |
| io_addr | input | ADDR_W (16) | Host I/O address |
| io_wr | input | 1 | Write strobe, one cycle per write |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, combinational from `io_addr`/`io_rd` |
| cfg_mode | output | 1 | 1 while in ST_CFG |
| dev_active | output | NUM_DEV | Activate bit per device |
| dev_base | output | NUM_DEV*16 | I/O base per device, device 0 in the low slice |
| dev_irq | output | NUM_DEV*IRQ_W | IRQ number per device |
| dev_mode | output | NUM_DEV*8 | Mode byte per device |
| pwr_en | output | 4 | Power enables {serial2, serial1, parallel, floppy} |
| osc_en | output | 1 | Oscillator and baud clock enable |

## Verification
The embedded properties check, on every cycle, the R1 and R2 key transitions, the rule that no output moves in the cycle after a locked cycle, the 0xFF read while locked, the freezing of every bank under a missing device number, and the bit mapping of power and activate writes. Three things only the bench scenarios can show: that banks stay separate across device numbers, that the strap moves the decode windows, and that reserved and unimplemented indices read back zero. The same holds for what reset clears after registers have been loaded. A behavioural reference model in the bench covers all of this by comparing every output and the read data on every clock.

// File: rtl/pnp_cfg_pkg.sv
package pnp_cfg_pkg;

    typedef enum logic [0:0] {
        ST_RUN = 1'b0,
        ST_CFG = 1'b1
    } cfg_state_e;

    localparam logic [7:0] KEY_ENTER   = 8'h55;
    localparam logic [7:0] KEY_EXIT    = 8'hAA;

    localparam logic [7:0] IDX_CFGCTL  = 8'h02;
    localparam logic [7:0] IDX_LDN     = 8'h07;
    localparam logic [7:0] IDX_PWR     = 8'h22;
    localparam logic [7:0] IDX_PM      = 8'h23;
    localparam logic [7:0] IDX_OSC     = 8'h24;

    localparam logic [7:0] IDX_DEV_LO  = 8'h30;
    localparam logic [7:0] IDX_ACT     = 8'h30;
    localparam logic [7:0] IDX_BASE_HI = 8'h60;
    localparam logic [7:0] IDX_BASE_LO = 8'h61;
    localparam logic [7:0] IDX_IRQ     = 8'h70;
    localparam logic [7:0] IDX_MODE    = 8'hF0;

    localparam logic [7:0] PWR_MASK    = 8'h39;
    localparam logic [7:0] OSC_MASK    = 8'h04;

endpackage

// File: rtl/pnp_cfg_keyfsm.sv
module pnp_cfg_keyfsm
    import pnp_cfg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       key_wr,
    input  logic [7:0] key_data,
    output logic       cfg_mode
);

    cfg_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: if (key_wr && key_data == KEY_ENTER) state_d = ST_CFG;
            ST_CFG: if (key_wr && key_data == KEY_EXIT)  state_d = ST_RUN;
            default: state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        cfg_mode = (state_q == ST_CFG);
    end

    a_r1_unlock: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_mode && key_wr && key_data == KEY_ENTER) |=> cfg_mode);

    a_r1_stay_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_mode && !(key_wr && key_data == KEY_ENTER)) |=> !cfg_mode);

    a_r2_lock: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode && key_wr && key_data == KEY_EXIT) |=> !cfg_mode);

endmodule

// File: rtl/pnp_cfg_global.sv
module pnp_cfg_global
    import pnp_cfg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] idx,
    input  logic [7:0] wdata,
    output logic [7:0] ldn,
    output logic [7:0] rd_data,
    output logic [3:0] pwr_en,
    output logic       osc_en
);

    logic [7:0] cc_q, ldn_q, pwr_q, pm_q, osc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cc_q  <= '0;
            ldn_q <= '0;
            pwr_q <= '0;
            pm_q  <= '0;
            osc_q <= '0;
        end else if (wr_en) begin
            case (idx)
                IDX_CFGCTL: cc_q  <= wdata;
                IDX_LDN:    ldn_q <= wdata;
                IDX_PWR:    pwr_q <= wdata & PWR_MASK;
                IDX_PM:     pm_q  <= wdata;
                IDX_OSC:    osc_q <= wdata & OSC_MASK;
                default:    ;
            endcase
        end
    end

    always_comb begin
        case (idx)
            IDX_CFGCTL: rd_data = cc_q;
            IDX_LDN:    rd_data = ldn_q;
            IDX_PWR:    rd_data = pwr_q;
            IDX_PM:     rd_data = pm_q;
            IDX_OSC:    rd_data = osc_q;
            default:    rd_data = 8'h00;
        endcase
    end

    assign ldn    = ldn_q;
    assign pwr_en = {pwr_q[5], pwr_q[4], pwr_q[3], pwr_q[0]};
    assign osc_en = osc_q[2];

    // R6: each power enable follows its own data bit after a power write
    a_r6_pwr_map: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && idx == IDX_PWR) |=>
        (pwr_en == {$past(wdata[5]), $past(wdata[4]), $past(wdata[3]), $past(wdata[0])}));

    a_r6_osc_map: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && idx == IDX_OSC) |=> (osc_en == $past(wdata[2])));

endmodule

// File: rtl/pnp_cfg_dev_bank.sv
module pnp_cfg_dev_bank
    import pnp_cfg_pkg::*;
#(
    parameter int IRQ_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [7:0]       idx,
    input  logic [7:0]       wdata,
    output logic             active,
    output logic [15:0]      base,
    output logic [IRQ_W-1:0] irq,
    output logic [7:0]       mode,
    output logic [7:0]       rd_data
);

    logic             act_q;
    logic [15:0]      base_q;
    logic [IRQ_W-1:0] irq_q;
    logic [7:0]       mode_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_q  <= 1'b0;
            base_q <= '0;
            irq_q  <= '0;
            mode_q <= '0;
        end else if (wr_en) begin
            case (idx)
                IDX_ACT:     act_q        <= wdata[0];
                IDX_BASE_HI: base_q[15:8] <= wdata;
                IDX_BASE_LO: base_q[7:0]  <= wdata;
                IDX_IRQ:     irq_q        <= wdata[IRQ_W-1:0];
                IDX_MODE:    mode_q       <= wdata;
                default:     ;
            endcase
        end
    end

    always_comb begin
        case (idx)
            IDX_ACT:     rd_data = {7'b0, act_q};
            IDX_BASE_HI: rd_data = base_q[15:8];
            IDX_BASE_LO: rd_data = base_q[7:0];
            IDX_IRQ:     rd_data = 8'(irq_q);
            IDX_MODE:    rd_data = mode_q;
            default:     rd_data = 8'h00;
        endcase
    end

    assign active = act_q;
    assign base   = base_q;
    assign irq    = irq_q;
    assign mode   = mode_q;

    a_r5_activate: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && idx == IDX_ACT) |=> (active == $past(wdata[0])));

    a_r5_no_write_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(active) && $stable(base) && $stable(irq) && $stable(mode)));

endmodule

// File: rtl/pnp_cfg_port.sv
module pnp_cfg_port
    import pnp_cfg_pkg::*;
#(
    parameter int                ADDR_W   = 16,
    parameter int                NUM_DEV  = 6,
    parameter int                IRQ_W    = 4,
    parameter logic [ADDR_W-1:0] BASE_PRI = 'h3F0,
    parameter logic [ADDR_W-1:0] BASE_ALT = 'h370
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     base_sel,
    input  logic [ADDR_W-1:0]        io_addr,
    input  logic                     io_wr,
    input  logic                     io_rd,
    input  logic [7:0]               io_wdata,
    output logic [7:0]               io_rdata,
    output logic                     cfg_mode,
    output logic [NUM_DEV-1:0]       dev_active,
    output logic [NUM_DEV*16-1:0]    dev_base,
    output logic [NUM_DEV*IRQ_W-1:0] dev_irq,
    output logic [NUM_DEV*8-1:0]     dev_mode,
    output logic [3:0]               pwr_en,
    output logic                     osc_en
);

    localparam logic [7:0] DEV_LIMIT = 8'(NUM_DEV);

    logic [ADDR_W-1:0] idx_addr, dat_addr;
    logic              hit_idx, hit_dat, key_wr, dat_wr, glob_we;
    logic [7:0]        idx_q, ldn, glob_rd, dev_sel_rd;
    logic [7:0]        dev_rd [NUM_DEV];
    logic [NUM_DEV-1:0] bank_we;

    assign idx_addr = base_sel ? BASE_ALT : BASE_PRI;
    assign dat_addr = idx_addr + ADDR_W'(1);
    assign hit_idx  = (io_addr == idx_addr);
    assign hit_dat  = (io_addr == dat_addr);
    assign key_wr   = io_wr && hit_idx;
    assign dat_wr   = cfg_mode && io_wr && hit_dat;
    assign glob_we  = dat_wr && (idx_q < IDX_DEV_LO);

    pnp_cfg_keyfsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .key_wr   (key_wr),
        .key_data (io_wdata),
        .cfg_mode (cfg_mode)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                     idx_q <= '0;
        else if (cfg_mode && key_wr && io_wdata != KEY_EXIT) idx_q <= io_wdata;
    end

    pnp_cfg_global u_glob (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (glob_we),
        .idx     (idx_q),
        .wdata   (io_wdata),
        .ldn     (ldn),
        .rd_data (glob_rd),
        .pwr_en  (pwr_en),
        .osc_en  (osc_en)
    );

    for (genvar g = 0; g < NUM_DEV; g++) begin : g_bank
        assign bank_we[g] = dat_wr && (idx_q >= IDX_DEV_LO) && (ldn == 8'(g));

        pnp_cfg_dev_bank #(.IRQ_W(IRQ_W)) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (bank_we[g]),
            .idx     (idx_q),
            .wdata   (io_wdata),
            .active  (dev_active[g]),
            .base    (dev_base[g*16 +: 16]),
            .irq     (dev_irq[g*IRQ_W +: IRQ_W]),
            .mode    (dev_mode[g*8 +: 8]),
            .rd_data (dev_rd[g])
        );
    end

    always_comb begin
        dev_sel_rd = 8'h00;
        for (int i = 0; i < NUM_DEV; i++) begin
            if (ldn == 8'(i)) dev_sel_rd = dev_rd[i];
        end
    end

    always_comb begin
        io_rdata = 8'hFF;
        if (io_rd && cfg_mode) begin
            if (hit_idx)      io_rdata = idx_q;
            else if (hit_dat) io_rdata = (idx_q < IDX_DEV_LO) ? glob_rd : dev_sel_rd;
        end
    end

    a_r7_locked_reads_ff: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_mode && io_rd) |-> (io_rdata == 8'hFF));

    a_r7_locked_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_mode |=> ($stable(dev_active) && $stable(dev_base) && $stable(dev_irq)
                       && $stable(dev_mode) && $stable(pwr_en) && $stable(osc_en)));

    a_r10_missing_ldn: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_wr && idx_q >= IDX_DEV_LO && ldn >= DEV_LIMIT) |=>
        ($stable(dev_active) && $stable(dev_base) && $stable(dev_irq) && $stable(dev_mode)));

    a_r2_exit_keeps_index: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode && key_wr && io_wdata == KEY_EXIT) |=> $stable(idx_q));

endmodule

// File: tb/pnp_cfg_port_tb_top.sv
module pnp_cfg_port_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NDEV       = 6;
    localparam int IRQW       = 4;

    logic        clk = 1'b0, rst_n = 1'b0, base_sel = 1'b0;
    logic        io_wr = 1'b0, io_rd = 1'b0;
    logic [15:0] io_addr = '0;
    logic [7:0]  io_wdata = '0;
    logic [7:0]  io_rdata;
    logic        cfg_mode, osc_en;
    logic [NDEV-1:0]      dev_active;
    logic [NDEV*16-1:0]   dev_base;
    logic [NDEV*IRQW-1:0] dev_irq;
    logic [NDEV*8-1:0]    dev_mode;
    logic [3:0]           pwr_en;

    always #(CLK_PERIOD/2) clk = ~clk;

    pnp_cfg_port dut_i (
        .clk(clk), .rst_n(rst_n), .base_sel(base_sel), .io_addr(io_addr),
        .io_wr(io_wr), .io_rd(io_rd), .io_wdata(io_wdata), .io_rdata(io_rdata),
        .cfg_mode(cfg_mode), .dev_active(dev_active), .dev_base(dev_base),
        .dev_irq(dev_irq), .dev_mode(dev_mode), .pwr_en(pwr_en), .osc_en(osc_en)
    );

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // behavioural reference model
    bit         m_cfg;
    int         m_idx, m_ldn, m_cc, m_pwr, m_pm, m_osc;
    int         m_act [NDEV];
    int         m_base[NDEV];
    int         m_irq [NDEV];
    int         m_mode[NDEV];

    function automatic int m_port();
        return base_sel ? 'h370 : 'h3F0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cfg = 0; m_idx = 0; m_ldn = 0; m_cc = 0; m_pwr = 0; m_pm = 0; m_osc = 0;
            for (int i = 0; i < NDEV; i++) begin
                m_act[i] = 0; m_base[i] = 0; m_irq[i] = 0; m_mode[i] = 0;
            end
        end else if (io_wr) begin
            if (!m_cfg) begin
                if (int'(io_addr) == m_port() && io_wdata == 8'h55) m_cfg = 1;
            end else if (int'(io_addr) == m_port()) begin
                if (io_wdata == 8'hAA) m_cfg = 0;
                else                   m_idx = io_wdata;
            end else if (int'(io_addr) == m_port() + 1) begin
                if (m_idx < 'h30) begin
                    if (m_idx == 'h02) m_cc  = io_wdata;
                    if (m_idx == 'h07) m_ldn = io_wdata;
                    if (m_idx == 'h22) m_pwr = io_wdata & 'h39;
                    if (m_idx == 'h23) m_pm  = io_wdata;
                    if (m_idx == 'h24) m_osc = io_wdata & 'h04;
                end else if (m_ldn < NDEV) begin
                    if (m_idx == 'h30) m_act[m_ldn]  = io_wdata & 1;
                    if (m_idx == 'h60) m_base[m_ldn] = (m_base[m_ldn] & 'hFF) | (int'(io_wdata) << 8);
                    if (m_idx == 'h61) m_base[m_ldn] = (m_base[m_ldn] & 'hFF00) | int'(io_wdata);
                    if (m_idx == 'h70) m_irq[m_ldn]  = io_wdata & 'hF;
                    if (m_idx == 'hF0) m_mode[m_ldn] = io_wdata;
                end
            end
        end
    end

    function automatic int m_rdata();
        if (!io_rd || !m_cfg) return 'hFF;
        if (int'(io_addr) == m_port()) return m_idx;
        if (int'(io_addr) != m_port() + 1) return 'hFF;
        if (m_idx < 'h30) begin
            case (m_idx)
                'h02: return m_cc;
                'h07: return m_ldn;
                'h22: return m_pwr;
                'h23: return m_pm;
                'h24: return m_osc;
                default: return 0;
            endcase
        end
        if (m_ldn >= NDEV) return 0;
        case (m_idx)
            'h30: return m_act[m_ldn];
            'h60: return m_base[m_ldn] >> 8;
            'h61: return m_base[m_ldn] & 'hFF;
            'h70: return m_irq[m_ldn];
            'hF0: return m_mode[m_ldn];
            default: return 0;
        endcase
    endfunction

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R1 cfg_mode vs model", cfg_mode, m_cfg);
            chk("R7 io_rdata vs model", io_rdata, m_rdata());
            chk("R6 pwr_en vs model", pwr_en,
                {28'b0, m_pwr[5], m_pwr[4], m_pwr[3], m_pwr[0]});
            chk("R6 osc_en vs model", osc_en, m_osc >> 2);
            for (int i = 0; i < NDEV; i++) begin
                chk("R5 dev_active vs model", dev_active[i], m_act[i]);
                chk("R5 dev_base vs model", dev_base[i*16 +: 16], m_base[i]);
                chk("R5 dev_irq vs model", dev_irq[i*IRQW +: IRQW], m_irq[i]);
                chk("R5 dev_mode vs model", dev_mode[i*8 +: 8], m_mode[i]);
            end
        end
    end

    logic [15:0] bp;

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(posedge clk); #(CLK_PERIOD/4);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(posedge clk); #(CLK_PERIOD/4);
        io_wr = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, input logic [7:0] exp, input string tag);
        @(posedge clk); #(CLK_PERIOD/4);
        io_addr = a; io_rd = 1'b1;
        @(negedge clk); #1;
        chk(tag, io_rdata, exp);
        io_rd = 1'b0;
    endtask

    task automatic cw(input logic [7:0] i, input logic [7:0] d);
        wr(bp, i);
        wr(bp + 16'd1, d);
    endtask

    task automatic cr(input logic [7:0] i, input logic [7:0] exp, input string tag);
        wr(bp, i);
        rd(bp + 16'd1, exp, tag);
    endtask

    task automatic do_reset();
        @(posedge clk); #(CLK_PERIOD/4);
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #(CLK_PERIOD/4);
        rst_n = 1'b1;
    endtask

    initial begin
        bp = 16'h3F0;
        repeat (3) @(posedge clk);
        #(CLK_PERIOD/4);
        rst_n = 1'b1;
        // R9 reset state
        chk("R9 reset cfg_mode", cfg_mode, 0);
        chk("R9 reset active", dev_active, 0);
        rd(16'h3F1, 8'hFF, "R7 locked data read");
        // R7 locked writes ignored
        wr(16'h3F0, 8'h22); wr(16'h3F1, 8'h39);
        chk("R7 locked write ignored", pwr_en, 0);
        // R1 wrong key
        wr(16'h3F0, 8'h56);
        chk("R1 wrong key stays locked", cfg_mode, 0);
        wr(16'h3F1, 8'h55);
        chk("R3 key at data port ignored", cfg_mode, 0);
        wr(16'h3F0, 8'h55);
        chk("R1 unlock", cfg_mode, 1);
        rd(16'h3F0, 8'h00, "R9 index reset value");
        cr(8'h07, 8'h00, "R4 ldn reset value");
        // R6 global space
        cw(8'h22, 8'hFF);
        chk("R6 pwr all", pwr_en, 4'hF);
        cr(8'h22, 8'h39, "R8 pwr reserved zero");
        cw(8'h22, 8'h10);
        chk("R6 pwr serial1 only", pwr_en, 4'b0100);
        cw(8'h24, 8'hFF);
        chk("R6 osc on", osc_en, 1);
        cr(8'h24, 8'h04, "R8 osc reserved zero");
        cw(8'h23, 8'hA5);
        cr(8'h23, 8'hA5, "R6 pm byte");
        cw(8'h02, 8'h3C);
        cr(8'h02, 8'h3C, "R6 cfgctl byte");
        cr(8'h10, 8'h00, "R8 unimplemented global");
        // R5 device 4
        cw(8'h07, 8'h04);
        cr(8'h07, 8'h04, "R4 ldn readback");
        cw(8'h60, 8'h03); cw(8'h61, 8'hF8); cw(8'h70, 8'hF4); cw(8'hF0, 8'h5A); cw(8'h30, 8'hFF);
        chk("R5 dev4 base", dev_base[4*16 +: 16], 16'h03F8);
        chk("R5 dev4 irq", dev_irq[4*IRQW +: IRQW], 4);
        chk("R5 dev4 mode", dev_mode[4*8 +: 8], 8'h5A);
        chk("R5 dev4 active only", dev_active, 6'b010000);
        cr(8'h70, 8'h04, "R8 irq reserved zero");
        cr(8'h30, 8'h01, "R8 activate reserved zero");
        cr(8'h31, 8'h00, "R8 unimplemented device index");
        // R5 bank separation
        cw(8'h07, 8'h01); cw(8'h60, 8'h02);
        chk("R5 dev1 base", dev_base[1*16 +: 16], 16'h0200);
        chk("R5 dev4 untouched", dev_base[4*16 +: 16], 16'h03F8);
        cr(8'h61, 8'h00, "R5 dev1 low byte");
        // R10 missing device
        cw(8'h07, 8'h09); cw(8'h30, 8'h01); cw(8'hF0, 8'h77);
        chk("R10 missing ldn no activate", dev_active, 6'b010000);
        cr(8'h30, 8'h00, "R10 missing ldn read zero");
        cw(8'h23, 8'h3C);
        cr(8'h23, 8'h3C, "R10 global still works");
        // R3 strap
        base_sel = 1'b1;
        wr(16'h3F0, 8'h07);
        rd(16'h3F0, 8'hFF, "R3 old index port dead");
        bp = 16'h370;
        rd(16'h370, 8'h23, "R3 alt index port");
        cr(8'h07, 8'h09, "R3 alt data port");
        // R2 exit
        wr(16'h370, 8'hAA);
        chk("R2 lock", cfg_mode, 0);
        wr(16'h371, 8'h00);
        rd(16'h371, 8'hFF, "R7 locked after exit");
        wr(16'h370, 8'hAA);
        chk("R1 exit key while locked", cfg_mode, 0);
        wr(16'h370, 8'h55);
        rd(16'h370, 8'h07, "R2 index kept across lock");
        // R9 reset after loading
        do_reset();
        chk("R9 reset locks", cfg_mode, 0);
        chk("R9 reset clears active", dev_active, 0);
        chk("R9 reset clears pwr", pwr_en, 0);
        wr(16'h370, 8'h55);
        cr(8'h07, 8'h00, "R9 ldn cleared");
        cr(8'h60, 8'h00, "R9 base cleared");
        repeat (2) @(posedge clk);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

endmodule